// File: doc/BRIEF.md
# Column-Compressed Multiply-Accumulate Unit

This block computes the unsigned expression `a * b + c` in a single combinational pass and presents the low bits of the result, optionally through an output register. The two operands default to 4 bits each, and the addend and the result default to 8 bits. Every partial-product bit is the AND of one bit of `a` and one bit of `b`. Partial product row `k` is `a` masked by bit `k` of `b` and weighted by 2^k. All of these rows and the addend are placed together as bits in weighted columns.

Each column is collapsed by a chain of full adders. Each full adder acts as a 3-to-2 compressor: it takes three bits of one column and returns a sum bit in that column and a carry bit one column to the left. The carries produced in a column become extra input bits of the next column up. Columns are handled from the least significant upward. When a column has an even bit count, its last compressor has one input tied to zero. The addend enters the tree as one more row, so no separate adder follows the multiplier. Carries out of the top column are dropped, so the result wraps modulo 2^R_W.

Top module: `mac_tree_mac`

## Requirements
- R1: With `en` high at a rising clock edge, `y` after that edge equals `(a*b + c) mod 256`, all values unsigned (defaults A_W=4, B_W=4, R_W=8).
- R2: When `a*b + c` exceeds 255, the bits above bit 7 are discarded; for example a=15, b=15, c=255 gives y=224.
- R3: With `en` low at a rising edge, `y` keeps its previous value whatever `a`, `b` and `c` do.
- R4: While `rst_n` is low, `y` is 0, and it becomes 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R5: If `a` is 0 or `b` is 0, a capture with `en` high gives `y = c`.
- R6: If `c` is 0, a capture with `en` high gives the exact product `a*b` (at most 225).
- R7: With the default registered output, a new input set appears on `y` one rising edge after it is applied and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and releases synchronously to clk |
| en | input | 1 | Clock enable for the output register |
| a | input | A_W | Unsigned multiplicand |
| b | input | B_W | Unsigned multiplier |
| c | input | R_W | Unsigned addend |
| y | output | R_W | Result, `(a*b + c) mod 2^R_W` |

## Verification
The hardest cases to reach are those that drive every compressor chain at once with all its inputs at one. In these cases the carries pile up in the middle columns and spill out of the top column. They occur only when both operands are large and the addend is large as well. The bench reaches them with a full sweep over all 65,536 combinations of `a`, `b` and `c`. It applies one new set each clock and compares each result with an arithmetic model. The wrap case, the zero-operand case and the zero-addend case each get their own check tags. Hold under a low enable and an asynchronous reset are tried at the ports after the sweep.

// File: rtl/mac_tree_pkg.sv
package mac_tree_pkg;

  // Number of partial-product bits that land in column col.
  function automatic int pp_cnt(input int col, input int aw, input int bw);
    int n;
    n = 0;
    for (int k = 0; k < bw; k++)
      if ((col - k) >= 0 && (col - k) < aw) n++;
    return n;
  endfunction

  // Position of the row-k partial product among the bits of column col.
  function automatic int pp_rank(input int col, input int k, input int aw);
    int n;
    n = 0;
    for (int kk = 0; kk < k; kk++)
      if ((col - kk) >= 0 && (col - kk) < aw) n++;
    return n;
  endfunction

  // Compressor count of column col (each one emits a carry upward).
  function automatic int fa_cnt(input int col, input int aw, input int bw);
    int cy;
    int n;
    cy = 0;
    for (int j = 0; j <= col; j++) begin
      n  = pp_cnt(j, aw, bw) + 1 + cy;
      cy = n / 2;
    end
    return cy;
  endfunction

  // Carry bits entering column col from the column below.
  function automatic int cin_cnt(input int col, input int aw, input int bw);
    return (col == 0) ? 0 : fa_cnt(col - 1, aw, bw);
  endfunction

  // Offset of column col's carries inside the flat carry vector.
  function automatic int cy_base(input int col, input int aw, input int bw);
    int s;
    s = 0;
    for (int j = 0; j < col; j++) s += fa_cnt(j, aw, bw);
    return s;
  endfunction

endpackage

// File: rtl/mac_fa3.sv
module mac_fa3 (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  logic xy;
  assign xy = x ^ y;
  assign s  = xy ^ z;
  assign co = (x & y) | (z & xy);
endmodule

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
  parameter int A_W = 4,
  parameter int B_W = 4
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W*B_W-1:0] pp
);
  // pp[k*A_W + i] carries weight i + k
  for (genvar k = 0; k < B_W; k++) begin : g_row
    for (genvar i = 0; i < A_W; i++) begin : g_bit
      assign pp[k*A_W + i] = a[i] & b[k];
    end
  end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree
  import mac_tree_pkg::*;
#(
  parameter int A_W = 4,
  parameter int B_W = 4,
  parameter int R_W = 8
) (
  input  logic [A_W*B_W-1:0] pp,
  input  logic [R_W-1:0]     addend,
  output logic [R_W-1:0]     sum
);
  // carries produced by every column except the top one
  localparam int CY_TOT = cy_base(R_W - 1, A_W, B_W);

  logic [CY_TOT-1:0] cy_all;

  for (genvar j = 0; j < R_W; j++) begin : g_col
    localparam int NP = pp_cnt(j, A_W, B_W);
    localparam int NC = cin_cnt(j, A_W, B_W);
    localparam int NB = NP + 1 + NC;
    localparam int NF = NB / 2;
    localparam int CB = cy_base(j, A_W, B_W);

    logic [NB-1:0] bits;
    logic [NF:0]   run;

    // partial products of this weight
    for (genvar k = 0; k < B_W; k++) begin : g_pp
      if ((j - k) >= 0 && (j - k) < A_W) begin : g_hit
        assign bits[pp_rank(j, k, A_W)] = pp[k*A_W + (j - k)];
      end
    end

    // addend bit as the extra row
    assign bits[NP] = addend[j];

    // carries arriving from the column below
    if (NC > 0) begin : g_cin
      localparam int CBL = cy_base(j - 1, A_W, B_W);
      for (genvar t = 0; t < NC; t++) begin : g_c
        assign bits[NP + 1 + t] = cy_all[CBL + t];
      end
    end

    // compressor chain: running sum plus two fresh bits per stage
    assign run[0] = bits[0];
    for (genvar t = 0; t < NF; t++) begin : g_fa
      logic third;
      if (2*t + 2 < NB) begin : g_full
        assign third = bits[2*t + 2];
      end else begin : g_pad
        assign third = 1'b0;
      end
      if (j < R_W - 1) begin : g_keep
        mac_fa3 u_fa (
          .x (run[t]),
          .y (bits[2*t + 1]),
          .z (third),
          .s (run[t + 1]),
          .co(cy_all[CB + t])
        );
      end else begin : g_drop
        // top column: carry weight 2^R_W is outside the result
        assign run[t + 1] = run[t] ^ bits[2*t + 1] ^ third;
      end
    end

    assign sum[j] = run[NF];
  end
endmodule

// File: rtl/mac_tree_mac.sv
module mac_tree_mac #(
  parameter int A_W     = 4,
  parameter int B_W     = 4,
  parameter int R_W     = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [R_W-1:0] c,
  output logic [R_W-1:0] y
);
  localparam int PP_W = A_W * B_W;

  logic [PP_W-1:0] pp;
  logic [R_W-1:0]  tree_sum;

  mac_pp_gen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a (a),
    .b (b),
    .pp(pp)
  );

  mac_csa_tree #(.A_W(A_W), .B_W(B_W), .R_W(R_W)) u_tree (
    .pp    (pp),
    .addend(c),
    .sum   (tree_sum)
  );

  if (REG_OUT) begin : g_reg
    logic [R_W-1:0] y_d;
    logic [R_W-1:0] y_q;

    always_comb begin
      y_d = y_q;
      if (en) y_d = tree_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y_q <= '0;
      else        y_q <= y_d;
    end

    assign y = y_q;
  end else begin : g_comb
    assign y = tree_sum;
  end
endmodule

// File: rtl/mac_tree_mac_chk.sv
module mac_tree_mac_chk #(
  parameter int A_W     = 4,
  parameter int B_W     = 4,
  parameter int R_W     = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [A_W-1:0] a,
  input logic [B_W-1:0] b,
  input logic [R_W-1:0] c,
  input logic [R_W-1:0] y,
  input logic [R_W-1:0] tree_sum
);
  logic [R_W-1:0] model;
  assign model = R_W'(a) * R_W'(b) + c;

  // R1 R2: compressor tree output matches modular arithmetic
  a_r1_tree_sum: assert property (@(posedge clk) disable iff (!rst_n)
    tree_sum == model);

  if (REG_OUT) begin : g_seq
    // R7: enabled capture shows on y one edge later
    a_r7_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> y == $past(model));

    // R3: y frozen while enable is low
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(y));

    // R5: zero operand passes the addend through
    a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (a == '0 || b == '0)) |=> y == $past(c));

    // R6: zero addend gives the bare product
    a_r6_pure_product: assert property (@(posedge clk) disable iff (!rst_n)
      (en && c == '0) |=> y == R_W'($past(a)) * R_W'($past(b)));

    // R4: reset holds the output at zero
    always @(posedge clk) begin
      if (!rst_n) a_r4_reset_zero: assert (y == '0);
    end
  end
endmodule

bind mac_tree_mac mac_tree_mac_chk #(
  .A_W(A_W), .B_W(B_W), .R_W(R_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .a       (a),
  .b       (b),
  .c       (c),
  .y       (y),
  .tree_sum(tree_sum)
);

// File: tb/mac_tree_mac_bench.sv
module mac_tree_mac_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [3:0] a;
  logic [3:0] b;
  logic [7:0] c;
  logic [7:0] y;

  int n_chk;
  int n_bad;
  bit done;

  mac_tree_mac u_mac_tree_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .a    (a),
    .b    (b),
    .c    (c),
    .y    (y)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: y=%0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog: run still going after %0d cycles, expected fewer", WDOG);
      report();
    end
  end

  initial begin
    logic [7:0] prev_exp;
    string      prev_tag;
    bit         have_prev;
    int         full;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    en    = 1'b0;
    a     = '0;
    b     = '0;
    c     = '0;
    have_prev = 1'b0;
    prev_exp  = '0;
    prev_tag  = "";

    repeat (3) @(negedge clk);
    chk(y, 8'd0, "R4 reset state");
    rst_n = 1'b1;

    // exhaustive sweep, one vector per clock, checked one edge later
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int ci = 0; ci < 256; ci++) begin
          @(negedge clk);
          if (have_prev) chk(y, prev_exp, prev_tag);
          a  = 4'(ai);
          b  = 4'(bi);
          c  = 8'(ci);
          en = 1'b1;
          full     = ai * bi + ci;
          prev_exp = 8'(full % 256);
          if (ai == 0 || bi == 0) prev_tag = "R5 zero operand";
          else if (ci == 0)       prev_tag = "R6 bare product";
          else if (full > 255)    prev_tag = "R2 wrap";
          else                    prev_tag = "R1 sum";
          have_prev = 1'b1;
        end
      end
    end
    @(negedge clk);
    chk(y, prev_exp, prev_tag);
    chk(y, 8'd224, "R2 15*15+255");

    // hold with enable low
    en = 1'b0;
    a  = 4'd7;
    b  = 4'd9;
    c  = 8'd3;
    repeat (3) begin
      @(negedge clk);
      chk(y, 8'd224, "R3 hold");
    end

    // one-edge latency
    a  = 4'd3;
    b  = 4'd5;
    c  = 8'd1;
    en = 1'b1;
    #1;
    chk(y, 8'd224, "R7 before edge");
    @(posedge clk);
    #1;
    chk(y, 8'd16, "R7 after edge");

    // asynchronous reset between edges
    @(negedge clk);
    en    = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(y, 8'd0, "R4 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(y, 8'd0, "R4 after release");

    done = 1'b1;
    report();
  end
endmodule